// File: doc/BRIEF.md
# Dual Programmable Video Clock Divider

This block runs on the pixel-rate dot clock and derives two slower timing signals from it: a shift-rate output intended for clocking video memory serial ports, and a video-rate output intended for blanking and sync generation. Both are taken from a single free-running counter. They therefore keep a fixed phase relationship to each other whatever ratios are chosen. Each ratio is set on its own by a 3-bit code, and the codes allow division by 1, 2, 4, 8, 16 or 32.

Each output is given in two forms. One is a level, which is the divided clock waveform. The other is a one-dot-cycle enable that marks the cycle just before that waveform rises. With the enable, logic can stay in the dot-clock domain and needs no derived clock.

A selection value that has bits 5, 4, 2 and 1 all set holds the counter at zero. Reset loads such a value. Several devices can therefore be brought to a common phase: each one is held in this pattern, and then all of them receive a valid selection on the same dot-clock edge.

Top module: `dotclk_divider_pair`

## Requirements
- R1: A synchronous active-high `rst` loads the selection value 0x36. While `rst` is high, and in the cycle after it, all four outputs are low.
- R2: `wr_data[2:0]` is the shift code and `wr_data[5:3]` is the video code. Code k (0 to 5) selects division by 2^k. A value written with `wr_en` high on an edge applies from that edge.
- R3: For a code k from 1 to 5, the level output equals bit k-1 of the shared counter. It is low for the first 2^(k-1) counts of each 2^k-count period and high for the rest.
- R4: Code 0 drives the level output high and the enable output high on every cycle.
- R5: For a code k from 1 to 5, the enable output is high for exactly one cycle per period. That cycle is the one in which the count modulo 2^k equals 2^(k-1)-1, so the level rises on the next edge.
- R6: While the stored selection has bits 5, 4, 2 and 1 all equal to 1, the counter is held at 0 and all outputs are low.
- R7: Codes 6 and 7 drive that output's level and enable low.
- R8: The counter is 5 bits wide and wraps modulo 32. When both codes are between 1 and 5, every fall of the slower level coincides with a fall of the faster level.
- R9: After a holding selection is replaced by a non-holding one on edge E, the counter reads 0 after E and reads n after the n-th edge following E. Both levels are therefore low in the first cycle.
- R10: A write that is not a holding pattern changes the ratios without disturbing the counter. The counter keeps incrementing across the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; loads the holding pattern |
| wr_en | input | 1 | Selection write strobe |
| wr_data | input | 6 | Selection value: video code [5:3], shift code [2:0] |
| shift_lvl | output | 1 | Divided shift-rate waveform |
| shift_ce | output | 1 | One-cycle pulse before each rising edge of `shift_lvl` |
| video_lvl | output | 1 | Divided video-rate waveform |
| video_ce | output | 1 | One-cycle pulse before each rising edge of `video_lvl` |

## Verification
The properties assume that `wr_data` is stable and known whenever `wr_en` is high. The edge-timing properties also assume that no write happens in the cycle they inspect. For that reason they look only at cycles in which `wr_en` was low on the previous edge. The stimulus changes inputs only on falling clock edges. It writes a new selection and then holds it for many cycles, so that full periods of every ratio can be observed between writes. It covers every code, both invalid codes, several holding patterns, and a write made while the counter is running.

// File: rtl/dcdiv_pkg.sv
package dcdiv_pkg;

    // Largest division exponent (2^5 = 32).
    localparam int MAX_LOG2 = 5;
    // The shared counter covers exactly the largest period.
    localparam int CNT_W    = MAX_LOG2;
    localparam int CODE_W   = 3;
    localparam int NUM_OUT  = 2;
    localparam int SEL_W    = NUM_OUT * CODE_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // Video code occupies the upper field, shift code the lower field.
    typedef struct packed {
        code_t video;
        code_t shift;
    } sel_t;

    typedef struct packed {
        logic lvl;
        logic ce;
    } tap_t;

    localparam sel_t HOLD_PATTERN = '{video: 3'b110, shift: 3'b110};

    function automatic logic is_hold(sel_t s);
        return s.video[2] & s.video[1] & s.shift[2] & s.shift[1];
    endfunction

    function automatic logic code_ok(code_t c);
        return int'(c) <= MAX_LOG2;
    endfunction

    function automatic cnt_t low_ones(int j);
        return cnt_t'((1 << j) - 1);
    endfunction

endpackage

// File: rtl/dcdiv_selreg.sv
module dcdiv_selreg
    import dcdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  sel_t wr_sel,
    output sel_t sel_q
);

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= HOLD_PATTERN;
        else if (wr_en)
            sel_q <= wr_sel;
    end

endmodule

// File: rtl/dcdiv_counter.sv
module dcdiv_counter
    import dcdiv_pkg::*;
#(
    parameter int WIDTH = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    output logic [WIDTH-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || hold)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/dcdiv_tap.sv
module dcdiv_tap
    import dcdiv_pkg::*;
#(
    parameter int LOG2_LIMIT = MAX_LOG2
) (
    input  code_t code,
    input  cnt_t  cnt,
    output tap_t  tap
);

    always_comb begin
        tap = '0;
        if (int'(code) <= LOG2_LIMIT) begin
            if (code == '0) begin
                tap.lvl = 1'b1;
                tap.ce  = 1'b1;
            end else begin
                for (int k = 1; k <= LOG2_LIMIT; k++) begin
                    if (int'(code) == k) begin
                        tap.lvl = cnt[k-1];
                        tap.ce  = !cnt[k-1] &&
                                  ((cnt & low_ones(k-1)) == low_ones(k-1));
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dotclk_divider_pair.sv
module dotclk_divider_pair
    import dcdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_data,
    output logic             shift_lvl,
    output logic             shift_ce,
    output logic             video_lvl,
    output logic             video_ce
);

    sel_t  sel_q;
    cnt_t  cnt;
    logic  hold;
    code_t codes [NUM_OUT];
    tap_t  taps  [NUM_OUT];

    dcdiv_selreg u_sel (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_sel (sel_t'(wr_data)),
        .sel_q  (sel_q)
    );

    assign hold = is_hold(sel_q);

    dcdiv_counter #(.WIDTH(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .hold (hold),
        .cnt  (cnt)
    );

    assign codes[0] = sel_q.shift;
    assign codes[1] = sel_q.video;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_tap
        dcdiv_tap #(.LOG2_LIMIT(MAX_LOG2)) u_tap (
            .code (codes[g]),
            .cnt  (cnt),
            .tap  (taps[g])
        );
    end

    assign shift_lvl = taps[0].lvl;
    assign shift_ce  = taps[0].ce;
    assign video_lvl = taps[1].lvl;
    assign video_ce  = taps[1].ce;

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> !shift_lvl && !video_lvl && !shift_ce && !video_ce);

    // R6
    hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        hold |-> !shift_lvl && !video_lvl && !shift_ce && !video_ce);

    // R5
    ce_leads_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_ce && !wr_en && sel_q.shift != '0 && code_ok(sel_q.shift))
        |=> $rose(shift_lvl));

    // R7
    bad_code_low_chk: assert property (@(posedge clk) disable iff (rst)
        !code_ok(sel_q.shift) |-> !shift_lvl && !shift_ce);

    // R8
    fall_align_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(video_lvl) && !$past(wr_en) && sel_q.shift != '0 &&
         code_ok(sel_q.video) && sel_q.video >= sel_q.shift)
        |-> $fell(shift_lvl));

endmodule

// File: tb/sim_dotclk_divider_pair.sv
`timescale 1ns/100ps
module sim_dotclk_divider_pair;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [5:0] wr_data = '0;
    logic       shift_lvl, shift_ce, video_lvl, video_ce;

    always #2.5 clk = ~clk;

    dotclk_divider_pair u0 (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .shift_lvl (shift_lvl),
        .shift_ce  (shift_ce),
        .video_lvl (video_lvl),
        .video_ce  (video_ce)
    );

    int vectors = 0;
    int miscompares = 0;
    logic done = 1'b0;

    // Reference state
    logic [5:0] m_sel = 6'h36;
    int         m_cnt = 0;

    logic [3:0] exp_q [$];
    string      tag_q [$];

    // {lvl, ce} for one output from its code and the count (R2, R3, R4, R5, R7)
    function automatic logic [1:0] ref_tap(int code, int count);
        int period;
        int ph;
        if (code > 5) return 2'b00;
        if (code == 0) return 2'b11;
        period = 1 << code;
        ph = count % period;
        return {ph >= period / 2, ph == period / 2 - 1};
    endfunction

    task automatic step(input logic r, input logic w, input logic [5:0] d,
                        input string tag);
        logic held;
        @(negedge clk);
        rst = r; wr_en = w; wr_data = d;
        @(posedge clk);
        held = m_sel[5] & m_sel[4] & m_sel[2] & m_sel[1];
        if (r) begin
            m_sel = 6'h36;
            m_cnt = 0;
        end else begin
            m_cnt = held ? 0 : (m_cnt + 1) % 32;
            if (w) m_sel = d;
        end
        exp_q.push_back({ref_tap(int'(m_sel[2:0]), m_cnt),
                         ref_tap(int'(m_sel[5:3]), m_cnt)});
        tag_q.push_back(tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 6'h00, tag);
    endtask

    // Monitor: compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                logic [3:0] e;
                logic [3:0] a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {shift_lvl, shift_ce, video_lvl, video_ce};
                vectors++;
                if (a !== e) begin
                    miscompares++;
                    $display("FAIL %s: {shift_lvl,shift_ce,video_lvl,video_ce} actual %b expected %b at %0t",
                             t, a, e, $time);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R1: watchdog, actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 6'h00, "R1");
        run(6, "R6");
        step(1'b0, 1'b1, 6'h11, "R9");          // video /4, shift /2
        run(40, "R3");
        step(1'b0, 1'b1, 6'h00, "R4");          // both /1
        run(6, "R4");
        step(1'b0, 1'b1, 6'h36, "R6");
        step(1'b0, 1'b1, 6'h2C, "R9");          // video /32, shift /16
        run(70, "R8");
        step(1'b0, 1'b1, 6'h3E, "R6");          // other holding pattern
        run(5, "R6");
        step(1'b0, 1'b1, 6'h23, "R2");          // video /16, shift /8
        run(40, "R2");
        step(1'b0, 1'b1, 6'h07, "R7");          // shift code 7, video /1
        run(10, "R7");
        step(1'b0, 1'b1, 6'h31, "R7");          // video code 6, shift /2
        run(10, "R7");
        step(1'b0, 1'b1, 6'h0A, "R10");         // video /2, shift /4, no hold
        run(20, "R10");
        step(1'b0, 1'b1, 6'h15, "R5");          // video /4, shift /32
        run(40, "R5");
        step(1'b0, 1'b1, 6'h1D, "R8");          // video /8, shift /32
        run(40, "R8");
        step(1'b1, 1'b0, 6'h00, "R1");
        step(1'b0, 1'b0, 6'h00, "R1");
        run(4, "R6");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule